// File: doc/BRIEF.md
# Coprocessor Bridge Interrupt and Control Register Bank

This block sits on the host processor's side of a bridge to an attached PC-compatible coprocessor. The host reaches it through byte writes to four write-only registers, placed at the odd byte offsets 1, 3, 5 and 7 above an aligned base address. Through them the host masks the PC-side events that may interrupt it, forces interrupt levels onto the PC, enables or disables its own interrupt, pulses the PC reset line, clears the printer BUSY flag and sends a keyboard character to the PC.

Write polarity is mixed. Forcing a PC interrupt level and each general control action happen when the host writes 0 to the matching bit; writing 1 to those bits does nothing. The keyboard start bit is the exception: it acts on a 1. The two IRQ3 force bits share one IRQ3 output. The printer BUSY flag is set by a strobe from the PC-side port decode and cleared by the host. The keyboard character is shifted out least significant bit first, one bit per programmable divider period. When the last bit is out, the block raises a keyboard event towards the host.

Top module: `pcbridge_regs`

## Requirements
- R1: A write takes effect only when `wr_addr` equals BASE+1 (mask), BASE+3 (PC interrupt control), BASE+5 (general control) or BASE+7 (keyboard data). A write to an even offset, or to an address outside the 8-byte window, changes nothing.
- R2: Mask register bit i set to 1 blocks event i from `host_irq`. The event order for bits 0 to 7 is: mouse, graphics, CRT 1, CRT 2, keyboard, printer 1, serial 2, system.
- R3: Writing 0 to bit 1, 2 or 3 of the PC interrupt control register latches force level A, force level B or the IRQ7 level. Writing 1 to these bits leaves them unchanged. `irq3` is the OR of levels A and B, and `irq7` is the third level.
- R4: Writing 0 to bit 3 of the general control register clears all three forced levels, starting the next cycle. The keyboard event is not cleared by this.
- R5: In the general control register, writing 0 to bit 0 enables `host_irq` and writing 0 to bit 1 disables it. When both bits are 0 in one write, the disable wins. The flag is disabled after reset.
- R6: `host_irq` = enable AND OR over i of (event i AND NOT mask i). It follows `evt_in` in the same cycle. Event bit 4 is `evt_in[4]` ORed with the internal keyboard-done event.
- R7: Writing 0 to bit 2 of the general control register drives `pc_reset` high for exactly RST_LEN cycles, starting in the cycle after the write.
- R8: `pc_busy_set` sets `lpt_busy` and writing 0 to bit 4 of the general control register clears it. When both happen in the same cycle, the set wins. General control bits 5 to 7 have no effect.
- R9: Writing 1 to bit 0 of the PC interrupt control register starts the shifter. `kbd_active` goes high and `kbd_sdata` presents bit i of the keyboard data register during cycles i*KBD_DIV to (i+1)*KBD_DIV-1 after the start write, for i = 0 to 7. `kbd_sdata` is 0 while idle.
- R10: After the 8th bit, `kbd_active` falls and the keyboard event (bit 4) becomes pending. An accepted start clears it. A start, or a keyboard data write, that arrives while the shifter is active does not change the bits being sent.
- R11: After reset, `irq3`, `irq7`, `host_irq`, `pc_reset`, `lpt_busy`, `kbd_sdata` and `kbd_active` are all 0, and the mask register is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_addr | input | ADDR_W | Host byte address |
| wr_data | input | 8 | Host write data |
| pc_busy_set | input | 1 | PC-side strobe that sets printer BUSY |
| evt_in | input | 8 | Pending PC-side events, bit order as in R2 |
| host_irq | output | 1 | Interrupt request to the host |
| irq3 | output | 1 | Forced IRQ3 level to the PC |
| irq7 | output | 1 | Forced IRQ7 level to the PC |
| pc_reset | output | 1 | Reset pulse to the PC |
| lpt_busy | output | 1 | Printer BUSY flag |
| kbd_sdata | output | 1 | Keyboard serial data |
| kbd_active | output | 1 | Keyboard shifter busy |

## Verification
The printer BUSY flag is the one state with two owners. The PC-side set strobe and a host clear write can land on the same clock edge. The bench raises `pc_busy_set` and a general control write with bit 4 at 0 on the same cycle, and requires `lpt_busy` to read 1 afterwards. It then confirms that a lone clear still drops the flag. A second pair of events that meet in one cycle is a keyboard restart arriving on the same edge as a bit shift. The bench places that write on a shift edge and checks that every later bit still comes from the first character.

// File: rtl/pcb_pkg.sv
// Package: shared offsets, bit positions and the decoded write-strobe type
// for the coprocessor bridge register bank.
// Assumes registers sit at odd byte offsets inside an 8-byte aligned window.
package pcb_pkg;

    localparam logic [2:0] OFS_MASK = 3'd1;
    localparam logic [2:0] OFS_INTC = 3'd3;
    localparam logic [2:0] OFS_GEN  = 3'd5;
    localparam logic [2:0] OFS_KBD  = 3'd7;

    // General control bits (active on a written 0)
    localparam int GEN_EN   = 0;
    localparam int GEN_DIS  = 1;
    localparam int GEN_RST  = 2;
    localparam int GEN_REL  = 3;
    localparam int GEN_BCLR = 4;
    localparam int GEN_USED = 5;

    // PC interrupt control bits
    localparam int INTC_KSTART = 0;
    localparam int INTC_FLO    = 1;
    localparam int INTC_FHI    = 3;

    // Event bit carrying the keyboard-done request
    localparam int KBD_EVT = 4;

    typedef struct packed {
        logic mask;
        logic intc;
        logic gen;
        logic kbd;
    } wstb_t;

endpackage

// File: rtl/pcb_decode.sv
// Module: address decoder. Turns a host byte write into one strobe per register.
// Assumes BASE is 8-byte aligned; the low three address bits pick the register.
module pcb_decode
    import pcb_pkg::*;
#(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE   = 16'hFFF8
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output wstb_t             stb
);

    localparam int HI = ADDR_W - 1;

    logic in_win;

    // Window match on the upper address bits
    always_comb in_win = wr_en && (wr_addr[HI:3] == BASE[HI:3]);

    // One strobe per odd offset; even offsets decode to nothing
    always_comb begin
        stb.mask = in_win && (wr_addr[2:0] == OFS_MASK);
        stb.intc = in_win && (wr_addr[2:0] == OFS_INTC);
        stb.gen  = in_win && (wr_addr[2:0] == OFS_GEN);
        stb.kbd  = in_win && (wr_addr[2:0] == OFS_KBD);
    end

endmodule

// File: rtl/pcb_force.sv
// Module: forced PC interrupt levels. One latch per force bit. A written 0
// sets the latch and the release strobe clears all of them.
// Assumes lanes 0 and 1 share IRQ3 and lane 2 drives IRQ7.
module pcb_force #(
    parameter int NF = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_stb,
    input  logic [NF-1:0] set_n,
    input  logic          rel,
    output logic          irq3,
    output logic          irq7
);

    logic [NF-1:0] lvl_q;

    for (genvar g = 0; g < NF; g++) begin : g_lane
        // Latch one forced level until the release strobe
        always_ff @(posedge clk) begin
            if (!rst_n)
                lvl_q[g] <= 1'b0;
            else if (rel)
                lvl_q[g] <= 1'b0;
            else if (set_stb && !set_n[g])
                lvl_q[g] <= 1'b1;
        end
    end

    // Merge lanes onto the two PC lines
    always_comb begin
        irq3 = lvl_q[0] | lvl_q[1];
        irq7 = lvl_q[2];
    end

endmodule

// File: rtl/pcb_kbdshift.sv
// Module: keyboard character shifter. Sends DBITS bits LSB first, each held
// for DIV cycles, and pulses done after the last bit.
// Assumes the caller only issues go while active is low; DIV >= 2.
module pcb_kbdshift #(
    parameter int DIV   = 250,
    parameter int DBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [DBITS-1:0] din,
    output logic             sdata,
    output logic             active,
    output logic             done
);

    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int BW = $clog2(DBITS + 1);
    localparam logic [DW-1:0] DLAST = DW'(DIV - 1);
    localparam logic [BW-1:0] BLAST = BW'(DBITS - 1);

    logic [DBITS-1:0] sh_q;
    logic [DW-1:0]    dc_q;
    logic [BW-1:0]    bc_q;
    logic             act_q;
    logic             done_q;

    // Load, divide and shift the character
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            dc_q   <= '0;
            bc_q   <= '0;
            act_q  <= 1'b0;
            done_q <= 1'b0;
        end else if (go) begin
            sh_q   <= din;
            dc_q   <= '0;
            bc_q   <= '0;
            act_q  <= 1'b1;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (act_q) begin
                if (dc_q == DLAST) begin
                    dc_q <= '0;
                    sh_q <= sh_q >> 1;
                    if (bc_q == BLAST) begin
                        bc_q   <= '0;
                        act_q  <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bc_q <= bc_q + BW'(1);
                    end
                end else begin
                    dc_q <= dc_q + DW'(1);
                end
            end
        end
    end

    // Drive outputs; line rests low when idle
    always_comb begin
        sdata  = act_q & sh_q[0];
        active = act_q;
        done   = done_q;
    end

endmodule

// File: rtl/pcbridge_regs.sv
// Module: top of the coprocessor bridge interrupt and control register bank.
// It decodes host byte writes, holds the mask, host enable, BUSY, reset timer
// and keyboard state, and builds the host interrupt.
// Assumes one host write per cycle and a single-cycle pc_busy_set strobe.
module pcbridge_regs
    import pcb_pkg::*;
#(
    parameter int                ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] BASE    = 16'hFFF8,
    parameter int                KBD_DIV = 250,
    parameter int                RST_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              pc_busy_set,
    input  logic [7:0]        evt_in,
    output logic              host_irq,
    output logic              irq3,
    output logic              irq7,
    output logic              pc_reset,
    output logic              lpt_busy,
    output logic              kbd_sdata,
    output logic              kbd_active
);

    localparam int RCW = $clog2(RST_LEN + 1);
    localparam int NF  = INTC_FHI - INTC_FLO + 1;

    wstb_t                stb;
    logic [GEN_USED-1:0]  fire;
    logic [7:0]           mask_q;
    logic [7:0]           kbd_q;
    logic                 host_en_q;
    logic                 busy_q;
    logic                 kbd_pend_q;
    logic [RCW-1:0]       rst_cnt_q;
    logic                 kbd_go;
    logic                 kbd_done;
    logic [7:0]           evt_all;

    pcb_decode #(
        .ADDR_W (ADDR_W),
        .BASE   (BASE)
    ) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .stb     (stb)
    );

    // Active-low general control bits become one-cycle action strobes
    always_comb fire = stb.gen ? ~wr_data[GEN_USED-1:0] : '0;

    // Keyboard start is active-high and accepted only while idle
    always_comb kbd_go = stb.intc && wr_data[INTC_KSTART] && !kbd_active;

    // Mask and keyboard data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            kbd_q  <= '0;
        end else begin
            if (stb.mask) mask_q <= wr_data;
            if (stb.kbd)  kbd_q  <= wr_data;
        end
    end

    // Host interrupt enable; disable beats enable
    always_ff @(posedge clk) begin
        if (!rst_n)
            host_en_q <= 1'b0;
        else if (fire[GEN_DIS])
            host_en_q <= 1'b0;
        else if (fire[GEN_EN])
            host_en_q <= 1'b1;
    end

    // Printer BUSY; the PC-side set beats the host clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_q <= 1'b0;
        else if (pc_busy_set)
            busy_q <= 1'b1;
        else if (fire[GEN_BCLR])
            busy_q <= 1'b0;
    end

    // PC reset pulse timer
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_cnt_q <= '0;
        else if (fire[GEN_RST])
            rst_cnt_q <= RCW'(RST_LEN);
        else if (rst_cnt_q != '0)
            rst_cnt_q <= rst_cnt_q - RCW'(1);
    end

    // Keyboard-done event: set at end of character, cleared by accepted start
    always_ff @(posedge clk) begin
        if (!rst_n)
            kbd_pend_q <= 1'b0;
        else if (kbd_done)
            kbd_pend_q <= 1'b1;
        else if (kbd_go)
            kbd_pend_q <= 1'b0;
    end

    pcb_force #(
        .NF (NF)
    ) u_frc (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (stb.intc),
        .set_n   (wr_data[INTC_FHI:INTC_FLO]),
        .rel     (fire[GEN_REL]),
        .irq3    (irq3),
        .irq7    (irq7)
    );

    pcb_kbdshift #(
        .DIV   (KBD_DIV),
        .DBITS (8)
    ) u_kbd (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (kbd_go),
        .din    (kbd_q),
        .sdata  (kbd_sdata),
        .active (kbd_active),
        .done   (kbd_done)
    );

    // Merge the keyboard event into the event vector and gate to the host
    always_comb begin
        evt_all          = evt_in;
        evt_all[KBD_EVT] = evt_in[KBD_EVT] | kbd_pend_q;
        host_irq         = host_en_q & |(evt_all & ~mask_q);
        pc_reset         = (rst_cnt_q != '0);
        lpt_busy         = busy_q;
    end

endmodule

// File: rtl/pcb_checker.sv
// Module: property checker for pcbridge_regs, attached by bind below.
// Assumes the top's port names and that reset is synchronous active-low.
module pcb_checker
    import pcb_pkg::*;
#(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE   = 16'hFFF8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [3:1]        gen_bits,
    input logic              pc_busy_set,
    input logic              host_irq,
    input logic              irq3,
    input logic              irq7,
    input logic              pc_reset,
    input logic              lpt_busy,
    input logic              kbd_sdata,
    input logic              kbd_active
);

    localparam logic [ADDR_W-1:0] GEN_A = {BASE[ADDR_W-1:3], OFS_GEN};

    logic gen_wr;
    always_comb gen_wr = wr_en && (wr_addr == GEN_A);

    AST_EVEN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr[0]) |=> ($stable(irq3) && $stable(irq7)));   // R1
    AST_FORCE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq7 && !(gen_wr && !gen_bits[3])) |=> irq7);                   // R3
    AST_RELEASE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_wr && !gen_bits[3]) |=> (!irq3 && !irq7));                  // R4
    AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_wr && !gen_bits[1]) |=> !host_irq);                         // R5
    AST_RESET_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pc_reset) |-> $past(gen_wr && !gen_bits[2]));              // R7
    AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        pc_busy_set |=> lpt_busy);                                       // R8
    AST_KBD_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !kbd_active |-> !kbd_sdata);                                     // R9

endmodule

bind pcbridge_regs pcb_checker #(
    .ADDR_W (ADDR_W),
    .BASE   (BASE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .gen_bits    (wr_data[3:1]),
    .pc_busy_set (pc_busy_set),
    .host_irq    (host_irq),
    .irq3        (irq3),
    .irq7        (irq7),
    .pc_reset    (pc_reset),
    .lpt_busy    (lpt_busy),
    .kbd_sdata   (kbd_sdata),
    .kbd_active  (kbd_active)
);

// File: tb/sim_pcbridge_regs.sv
// Bench: vector table walked by one loop, then directed reset, BUSY,
// reset-pulse and keyboard tests. 50 MHz clock.
module sim_pcbridge_regs;

    localparam int DIV  = 4;
    localparam int RLEN = 5;
    localparam int NV   = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        pc_busy_set = 1'b0;
    logic [7:0]  evt_in = '0;
    logic        host_irq, irq3, irq7, pc_reset, lpt_busy, kbd_sdata, kbd_active;

    int n_chk = 0;
    int n_bad = 0;
    int t = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    pcbridge_regs #(
        .ADDR_W  (16),
        .BASE    (16'hFFF8),
        .KBD_DIV (DIV),
        .RST_LEN (RLEN)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .pc_busy_set (pc_busy_set), .evt_in (evt_in),
        .host_irq (host_irq), .irq3 (irq3), .irq7 (irq7), .pc_reset (pc_reset),
        .lpt_busy (lpt_busy), .kbd_sdata (kbd_sdata), .kbd_active (kbd_active)
    );

    // {addr, data, evt, exp_irq3, exp_irq7, exp_host_irq}
    localparam logic [34:0] VEC [NV] = '{
        {16'hFFFD, 8'hFE, 8'h01, 3'b001},
        {16'hFFF9, 8'h01, 8'h01, 3'b000},
        {16'hFFF9, 8'h01, 8'h02, 3'b001},
        {16'hFFFB, 8'hFD, 8'h00, 3'b100},
        {16'hFFFB, 8'hFE, 8'h00, 3'b100},
        {16'hFFFD, 8'hF7, 8'h00, 3'b000},
        {16'hFFFB, 8'hF6, 8'h00, 3'b010},
        {16'hFFFA, 8'h00, 8'h00, 3'b010},
        {16'hEFFB, 8'h00, 8'h00, 3'b010},
        {16'hFFFB, 8'hFA, 8'h00, 3'b110},
        {16'hFFFD, 8'hF7, 8'h00, 3'b000},
        {16'hFFFD, 8'hFC, 8'h80, 3'b000},
        {16'hFFFD, 8'hFE, 8'h80, 3'b001},
        {16'hFFF9, 8'h80, 8'h80, 3'b000},
        {16'hFFF9, 8'h00, 8'h10, 3'b001},
        {16'hFFFD, 8'hFD, 8'h10, 3'b000}
    };
    string VTAG [NV] = '{"R5", "R2", "R2", "R3", "R3", "R4", "R3", "R1",
                         "R1", "R3", "R4", "R5", "R6", "R2", "R6", "R5"};

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        t += 2;
    endtask

    task automatic goto(input int tgt);
        while (t < tgt) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    logic [7:0] ch;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        evt_in = 8'hFF;
        @(negedge clk);
        // R11 reset state
        check("R11 irq3", {7'd0, irq3}, 8'd0);
        check("R11 irq7", {7'd0, irq7}, 8'd0);
        check("R11 host_irq", {7'd0, host_irq}, 8'd0);
        check("R11 pc_reset", {7'd0, pc_reset}, 8'd0);
        check("R11 lpt_busy", {7'd0, lpt_busy}, 8'd0);
        check("R11 kbd", {6'd0, kbd_sdata, kbd_active}, 8'd0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            evt_in = VEC[i][10:3];
            wr(VEC[i][34:19], VEC[i][18:11]);
            check({VTAG[i], " vec outputs"}, {5'd0, irq3, irq7, host_irq},
                  {5'd0, VEC[i][2:0]});
        end

        // R7 reset pulse length
        evt_in = 8'h00;
        wr(16'hFFFD, 8'hFB);
        for (int k = 0; k < RLEN; k++) begin
            check("R7 pc_reset high", {7'd0, pc_reset}, 8'd1);
            @(negedge clk);
        end
        check("R7 pc_reset low", {7'd0, pc_reset}, 8'd0);

        // R8 BUSY set, ignored high bits, clear, simultaneous
        @(negedge clk); pc_busy_set = 1'b1;
        @(negedge clk); pc_busy_set = 1'b0;
        check("R8 busy set", {7'd0, lpt_busy}, 8'd1);
        wr(16'hFFFD, 8'h1F);
        check("R8 bits 5-7 ignored", {4'd0, lpt_busy, pc_reset, irq3, irq7}, 8'h8);
        wr(16'hFFFD, 8'hEF);
        check("R8 busy cleared", {7'd0, lpt_busy}, 8'd0);
        @(negedge clk);
        pc_busy_set = 1'b1; wr_en = 1'b1; wr_addr = 16'hFFFD; wr_data = 8'hEF;
        @(negedge clk);
        pc_busy_set = 1'b0; wr_en = 1'b0;
        check("R8 set beats clear", {7'd0, lpt_busy}, 8'd1);
        wr(16'hFFFD, 8'hEF);
        check("R8 lone clear", {7'd0, lpt_busy}, 8'd0);

        // R9/R10 keyboard character A5
        wr(16'hFFFD, 8'hFE);
        wr(16'hFFFF, 8'hA5);
        wr(16'hFFFB, 8'hFF);
        t = 0;
        ch = 8'hA5;
        check("R9 active after start", {7'd0, kbd_active}, 8'd1);
        for (int i = 0; i < 8; i++) begin
            goto(i * DIV + 1);
            check("R9 serial bit", {7'd0, kbd_sdata}, {7'd0, ch[i]});
        end
        goto(8 * DIV + 2);
        check("R10 idle after char", {7'd0, kbd_active}, 8'd0);
        check("R10 keyboard event", {7'd0, host_irq}, 8'd1);

        // R10 second character 3C with a restart on a shift edge
        wr(16'hFFFF, 8'h3C);
        wr(16'hFFFB, 8'hFF);
        t = 0;
        ch = 8'h3C;
        check("R10 event cleared by start", {7'd0, host_irq}, 8'd0);
        check("R9 bit0 of second char", {7'd0, kbd_sdata}, {7'd0, ch[0]});
        wr(16'hFFFF, 8'h00);
        wr(16'hFFFB, 8'hFF);
        for (int i = 1; i < 8; i++) begin
            goto(i * DIV + 1);
            check("R10 bits kept during restart", {7'd0, kbd_sdata}, {7'd0, ch[i]});
        end
        goto(8 * DIV + 2);
        check("R10 second char done", {6'd0, kbd_active, host_irq}, 8'd1);
        wr(16'hFFF9, 8'h10);
        check("R2 keyboard event masked", {7'd0, host_irq}, 8'd0);

        finish_run();
    end

endmodule